// File: doc/BRIEF.md
# Lane-wise binary64 compare-to-mask unit

This unit compares two vectors of IEEE binary64 numbers lane by lane under one predicate shared by all lanes. Each lane yields a mask of its full width, all ones when the predicate holds and all zeros when it does not. An invalid-operation flag is raised when any lane meets an invalid condition. Both results are captured in registers on the clock edge where the input strobe is high. They keep their values while the strobe is low.

The 4-bit predicate code has three parts. Bits [1:0] pick the relation. Bit 2 inverts the ordered result and makes an unordered lane true. Bit 3 makes a quiet NaN raise invalid. The relation is evaluated on sign/magnitude values, so negative numbers order below positive ones and below each other by descending magnitude. Subnormals are compared exactly as encoded.

Top module: `fpcmp_mask_unit`

## Requirements
- R1: Lane l occupies bits [64*l+63 : 64*l] of each operand and of the mask. Every mask lane is either all ones or all zeros, and it is updated on the first rising clock edge where in_valid is high.
- R2: Predicate bits [1:0] pick the relation for an ordered lane: 00 is a==b, 01 is a<b, 10 is a<=b, and 11 is always false.
- R3: When predicate bit 2 is set, the result of an ordered lane is the inverse of the relation selected by bits [1:0].
- R4: A lane is unordered when either operand is a NaN (exponent all ones, fraction nonzero). An unordered lane is false when bit 2 is clear and true when bit 2 is set, whatever bits [1:0] hold.
- R5: Ordering follows the sign/magnitude value and not the raw unsigned bit pattern. For example, -2.0 < -1.0 < +1.0.
- R6: +0 and -0 compare equal in every lane.
- R7: A quiet NaN (fraction MSB = 1) raises invalid only when predicate bit 3 is set.
- R8: A signalling NaN (fraction MSB = 0, fraction nonzero) raises invalid under every predicate.
- R9: res_invalid is the OR of the invalid conditions of all lanes.
- R10: After reset, res_mask and res_invalid are zero. While in_valid is low, both keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_pred | input | 4 | Predicate code |
| in_a | input | 128 | First operand vector |
| in_b | input | 128 | Second operand vector |
| res_mask | output | 128 | Per-lane result mask |
| res_invalid | output | 1 | Aggregated invalid-operation flag |

## Verification
The mask and the invalid flag are both due on the first rising edge after a strobe is presented. The bench drives each stimulus on a falling edge. It updates its behavioural expectation at the rising edge only when the strobe was high, and it compares both outputs 1 ns after that edge. Cycles with the strobe low are compared against the held expectation, which checks R10 at the ports. The bench's expected relations come from real-number comparison of the decoded operands, with NaNs classified from their bit fields.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   localparam int PRED_W = 4;

   typedef enum logic [1:0] {
      REL_EQ   = 2'b00,
      REL_LT   = 2'b01,
      REL_LE   = 2'b10,
      REL_NONE = 2'b11
   } rel_e;

   // bit 3 signalling on quiet NaN, bit 2 invert/unordered-true, [1:0] relation
   typedef struct packed {
      logic signal_qnan;
      logic negate;
      rel_e rel;
   } pred_t;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
   } fclass_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] val,
   output fpcmp_pkg::fclass_t    cls
);
   localparam int ELEM_W = 1 + EXP_W + FRAC_W;

   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;
   logic              exp_max;
   logic              frac_nz;

   assign expo    = val[ELEM_W-2 -: EXP_W];
   assign frac    = val[FRAC_W-1:0];
   assign exp_max = &expo;
   assign frac_nz = |frac;

   always_comb begin
      cls.is_nan  = exp_max && frac_nz;
      cls.is_snan = exp_max && frac_nz && !frac[FRAC_W-1];
      cls.is_zero = (expo == '0) && !frac_nz;
   end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   input  logic                  zero_a,
   input  logic                  zero_b,
   output logic                  is_eq,
   output logic                  is_lt
);
   localparam int ELEM_W = 1 + EXP_W + FRAC_W;
   localparam int MAG_W  = ELEM_W - 1;

   logic             sgn_a, sgn_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   logic             both_zero;
   logic             mag_lt, mag_gt;

   assign sgn_a     = op_a[ELEM_W-1];
   assign sgn_b     = op_b[ELEM_W-1];
   assign mag_a     = op_a[MAG_W-1:0];
   assign mag_b     = op_b[MAG_W-1:0];
   assign both_zero = zero_a && zero_b;
   assign mag_lt    = mag_a < mag_b;
   assign mag_gt    = mag_a > mag_b;

   always_comb begin
      is_eq = both_zero || (op_a == op_b);
      if (both_zero)
         is_lt = 1'b0;
      else if (sgn_a != sgn_b)
         is_lt = sgn_a;
      else if (!sgn_a)
         is_lt = mag_lt;
      else
         is_lt = mag_gt;
   end
endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   input  pred_t                 pred,
   output logic                  hit,
   output logic                  invalid,
   output logic                  unordered,
   output logic                  has_snan,
   output logic                  both_zero
);
   fclass_t cls_a, cls_b;
   logic    rel_eq, rel_lt, rel_val;

   fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.val(op_a), .cls(cls_a));
   fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.val(op_b), .cls(cls_b));

   fpcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
      .op_a   (op_a),
      .op_b   (op_b),
      .zero_a (cls_a.is_zero),
      .zero_b (cls_b.is_zero),
      .is_eq  (rel_eq),
      .is_lt  (rel_lt)
   );

   always_comb begin
      unique case (pred.rel)
         REL_EQ:  rel_val = rel_eq;
         REL_LT:  rel_val = rel_lt;
         REL_LE:  rel_val = rel_lt || rel_eq;
         default: rel_val = 1'b0;
      endcase
   end

   assign unordered = cls_a.is_nan || cls_b.is_nan;
   assign has_snan  = cls_a.is_snan || cls_b.is_snan;
   assign both_zero = cls_a.is_zero && cls_b.is_zero;
   assign hit       = unordered ? pred.negate : (rel_val ^ pred.negate);
   assign invalid   = has_snan || (pred.signal_qnan && unordered);
endmodule

// File: rtl/fpcmp_mask_unit.sv
module fpcmp_mask_unit
   import fpcmp_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic [PRED_W-1:0]                in_pred,
   input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] in_a,
   input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] in_b,
   output logic [LANES*(1+EXP_W+FRAC_W)-1:0] res_mask,
   output logic                             res_invalid
);
   localparam int ELEM_W = 1 + EXP_W + FRAC_W;
   localparam int VEC_W  = LANES * ELEM_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("fpcmp_mask_unit: LANES must be at least 1");
   end
   if (EXP_W < 2) begin : g_bad_exp
      $error("fpcmp_mask_unit: EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fpcmp_mask_unit: FRAC_W must be at least 2");
   end

   pred_t            pred;
   logic [LANES-1:0] lane_hit, lane_inv, lane_unord, lane_snan, lane_zero;
   logic [VEC_W-1:0] mask_d;

   assign pred = pred_t'(in_pred);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      fpcmp_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
         .op_a      (in_a[l*ELEM_W +: ELEM_W]),
         .op_b      (in_b[l*ELEM_W +: ELEM_W]),
         .pred      (pred),
         .hit       (lane_hit[l]),
         .invalid   (lane_inv[l]),
         .unordered (lane_unord[l]),
         .has_snan  (lane_snan[l]),
         .both_zero (lane_zero[l])
      );
      assign mask_d[l*ELEM_W +: ELEM_W] = {ELEM_W{lane_hit[l]}};

      // R1
      mask_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (res_mask[l*ELEM_W +: ELEM_W] == '0) || (res_mask[l*ELEM_W +: ELEM_W] == '1));

      // R4
      unord_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && lane_unord[l] && !in_pred[2] |=> res_mask[l*ELEM_W +: ELEM_W] == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_mask    <= '0;
         res_invalid <= 1'b0;
      end else if (in_valid) begin
         res_mask    <= mask_d;
         res_invalid <= |lane_inv;
      end
   end

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res_mask) && $stable(res_invalid));

   // R8
   snan_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (|lane_snan) |=> res_invalid);

   // R2
   never_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_pred[1:0] == 2'b11 && !in_pred[2] |=> res_mask == '0);

   // R6
   zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_pred == 4'b0000 && (&lane_zero) |=> res_mask == '1);

   // R7
   quiet_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_pred[3] && !(|lane_snan) |=> !res_invalid);
endmodule

// File: tb/fpcmp_mask_unit_test.sv
module fpcmp_mask_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   in_pred = '0;
   logic [127:0] in_a = '0, in_b = '0;
   logic [127:0] res_mask;
   logic         res_invalid;

   int checks = 0, errors = 0;
   logic [127:0] exp_mask = '0;
   logic         exp_inv = 1'b0;

   localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000,
      N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000, PZ = 64'h0,
      NZ = 64'h8000000000000000, QN = 64'h7FF8000000000000, SN = 64'h7FF0000000000001,
      PI = 64'h7FF0000000000000, S3 = 64'h0000000000000123, S4 = 64'h0000000000000124;

   always #5 clk = ~clk;

   fpcmp_mask_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pred(in_pred),
      .in_a(in_a), .in_b(in_b), .res_mask(res_mask), .res_invalid(res_invalid));

   function automatic logic is_nan(input logic [63:0] x);
      return x[62:52] == 11'h7FF && x[51:0] != 0;
   endfunction

   function automatic logic ref_lane(input logic [63:0] a, input logic [63:0] b,
                                     input logic [3:0] p, output logic inv);
      logic un, rel;
      real ra, rb;
      un  = is_nan(a) || is_nan(b);
      inv = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]) || (p[3] && un);
      if (un) return p[2];
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      case (p[1:0])
         2'b00: rel = (ra == rb);
         2'b01: rel = (ra < rb);
         2'b10: rel = (ra <= rb);
         default: rel = 1'b0;
      endcase
      return rel ^ p[2];
   endfunction

   task automatic compare(input string req);
      checks++;
      if (res_mask !== exp_mask || res_invalid !== exp_inv) begin
         errors++;
         $display("FAIL %s: mask=%h inv=%b expected mask=%h inv=%b",
                  req, res_mask, res_invalid, exp_mask, exp_inv);
      end
   endtask

   task automatic apply(input logic [63:0] a1, input logic [63:0] a0, input logic [63:0] b1,
                        input logic [63:0] b0, input logic [3:0] p, input logic v, input string req);
      logic i0, i1, h0, h1;
      @(negedge clk);
      in_a = {a1, a0}; in_b = {b1, b0}; in_pred = p; in_valid = v;
      @(posedge clk);
      if (v) begin
         h0 = ref_lane(a0, b0, p, i0);
         h1 = ref_lane(a1, b1, p, i1);
         exp_mask = {{64{h1}}, {64{h0}}};
         exp_inv  = i0 | i1;
      end
      #1 compare(req);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] pool [10];
      pool = '{P1, P2, N1, N2, PZ, NZ, QN, SN, PI, S3};
      repeat (3) @(posedge clk);
      #1 compare("R10 reset");
      rst_n = 1'b1;
      apply(P1, P1, P2, P1, 4'b0000, 1, "R2 eq");
      apply(P2, P1, P1, P2, 4'b0001, 1, "R2 lt");
      apply(P1, P2, P1, P1, 4'b0010, 1, "R2 le");
      apply(P1, N1, P2, P1, 4'b0011, 1, "R2 false");
      apply(P2, P1, P1, P2, 4'b0101, 1, "R3 not-lt");
      apply(P1, P2, P1, P1, 4'b0110, 1, "R3 not-le");
      apply(QN, P1, P1, QN, 4'b0001, 1, "R4 unordered false");
      apply(QN, P1, P1, QN, 4'b0101, 1, "R4 unordered true");
      apply(QN, P1, P1, P2, 4'b0111, 1, "R4 unordered true-always");
      apply(N2, N1, N1, P1, 4'b0001, 1, "R5 negatives");
      apply(S3, N1, S4, N2, 4'b0001, 1, "R5 subnormal/neg");
      apply(NZ, PZ, PZ, NZ, 4'b0000, 1, "R6 signed zeros");
      apply(NZ, PZ, PZ, NZ, 4'b0001, 1, "R6 zero not lt");
      apply(QN, P1, P1, P1, 4'b0001, 1, "R7 quiet no invalid");
      apply(P1, QN, P1, P1, 4'b1001, 1, "R7 quiet signals");
      apply(P1, SN, P1, P1, 4'b0000, 1, "R8 snan quiet pred");
      apply(P1, P1, SN, P1, 4'b0110, 1, "R8 snan lane1");
      apply(P1, P1, P1, P1, 4'b0000, 1, "R1 mask all ones");
      apply(P2, P1, QN, P1, 4'b0000, 0, "R10 hold");
      apply(P1, SN, P1, P1, 4'b0011, 0, "R10 hold invalid");
      apply(QN, P1, P1, P1, 4'b1000, 1, "R9 lane1 invalid");
      apply(P1, PI, P1, QN, 4'b1010, 1, "R9 lane0 invalid");
      for (int k = 0; k < 300; k++) begin
         apply(pool[$urandom_range(9)], pool[$urandom_range(9)], pool[$urandom_range(9)],
               pool[$urandom_range(9)], 4'($urandom), 1'($urandom_range(3) != 0), "R1 random");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule